// File: doc/BRIEF.md
# Dual Wiper Register File with Access Control

This block is the register map that sits behind a serial slave controlling two digital potentiometers. It holds a live 8-bit wiper setting per channel and a persistent initial setting per channel. It also holds five general-purpose persistent bytes, a reserved slot, and a volatile mode byte that decides whether the channel addresses reach the live copy alone or the persistent copy as well. The serial front end presents a simple register bus: an address, write data with a strobe, and a pulse when the bus transaction ends (STOP). Read data comes back combinationally from the address.

Persistent storage is modelled as a flop array behind a commit port. A write that must reach persistent storage is parked in a single staging slot. It is programmed into the array, and announced on the commit port, at the next STOP. The live wiper registers drive the two wiper outputs directly. In persistent mode, a channel write updates the live wiper at once and the persistent copy at STOP, so a persistent value is never stored without the matching live value.

Top module: `dual_wiper_regfile`

## Requirements
- R1: After reset both wiper outputs are 80h, both initial-value bytes read 80h, general-purpose bytes read 00h, the mode byte (address 8) reads 00h and no commit is signalled.
- R2: The mode byte at address 8 accepts only the values 00h (persistent mode) and 80h (volatile mode). A write of any other value leaves it unchanged. A read of address 8 returns its current value.
- R3: In persistent mode, a write to address 0 or 1 updates that channel's wiper and stages the byte for commit. A read of address 0 or 1 returns the stored initial value, not the live wiper. The other channel is unaffected.
- R4: In volatile mode, a write to address 0 or 1 updates only that wiper, a read returns the live wiper, and no commit follows at STOP.
- R5: A STOP with a staged write raises nv_commit for exactly one cycle, in the cycle after the STOP strobe, with nv_addr and nv_data showing the staged address and byte. From that cycle on, reads return the new value.
- R6: A STOP with nothing staged produces no commit.
- R7: General-purpose addresses 2 to 6 are written through the commit path in persistent mode. In volatile mode, their reads return 00h and their writes are ignored.
- R8: Writes to address 7 and to addresses 9 to 15 are ignored and cause no commit. Reads of those addresses return 00h.
- R9: Only one write is staged. If several persistent writes arrive before a STOP, the last one is committed and the earlier ones are lost.
- R10: A wiper change is visible on the wiper output in the cycle after the write strobe, not before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset (power-up) |
| wr_en | input | 1 | Write strobe, one cycle per byte |
| bus_stop | input | 1 | Pulse marking the end of a bus transaction |
| addr | input | 4 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for addr (combinational) |
| wiper0 | output | 8 | Live setting of channel 0 |
| wiper1 | output | 8 | Live setting of channel 1 |
| nv_commit | output | 1 | One-cycle pulse: persistent byte programmed |
| nv_addr | output | 3 | Address of the committed byte |
| nv_data | output | 8 | Value of the committed byte |

## Verification
The hardest state to reach is the window between a persistent write and its STOP. In that window the live wiper already holds the new value while the persistent copy still holds the old one. The stimulus writes a channel in persistent mode and reads the same address before issuing STOP, which exposes the stale initial value. It then issues STOP and reads again. A second sequence stacks two general-purpose writes before one STOP, to show that only the last reaches storage. A write issued in volatile mode followed by a STOP shows that the staging slot stays empty.

// File: rtl/dual_wiper_regfile.sv
module dual_wiper_regfile #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          bus_stop,
  input  logic [3:0]    addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic [DW-1:0] wiper0,
  output logic [DW-1:0] wiper1,
  output logic          nv_commit,
  output logic [2:0]    nv_addr,
  output logic [DW-1:0] nv_data
);
  localparam logic [DW-1:0] MID = DW'(1) << (DW-1);
  localparam int NVB = 7;

  logic [DW-1:0] live [2];
  logic [DW-1:0] nv   [NVB];
  logic          vol_mode;
  logic          pend_v;
  logic [2:0]    pend_a;
  logic [DW-1:0] pend_d;

  wire in_nv   = addr < 4'd7;
  wire is_dcp  = addr < 4'd2;
  wire is_mode = addr == 4'd8;
  wire wr_live = wr_en && is_dcp;
  wire wr_nv   = wr_en && in_nv && !vol_mode;
  wire wr_mode = wr_en && is_mode && (wdata == '0 || wdata == MID);

  always_comb begin
    rdata = '0;
    if (is_dcp)      rdata = vol_mode ? live[addr[0]] : nv[addr[2:0]];
    else if (in_nv)  rdata = vol_mode ? '0 : nv[addr[2:0]];
    else if (is_mode) rdata = vol_mode ? MID : '0;
  end

  assign wiper0 = live[0];
  assign wiper1 = live[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live[0]  <= MID;
      live[1]  <= MID;
      vol_mode <= 1'b0;
    end else begin
      if (wr_live) live[addr[0]] <= wdata;
      if (wr_mode) vol_mode <= wdata[DW-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NVB; i++) nv[i] <= (i < 2) ? MID : '0;
      pend_v    <= 1'b0;
      pend_a    <= '0;
      pend_d    <= '0;
      nv_commit <= 1'b0;
      nv_addr   <= '0;
      nv_data   <= '0;
    end else begin
      nv_commit <= 1'b0;
      if (bus_stop && pend_v) begin
        nv[pend_a] <= pend_d;
        nv_commit  <= 1'b1;
        nv_addr    <= pend_a;
        nv_data    <= pend_d;
        pend_v     <= 1'b0;
      end
      if (wr_nv) begin
        pend_v <= 1'b1;
        pend_a <= addr[2:0];
        pend_d <= wdata;
      end
    end
  end

  AST_MODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    is_mode |-> (rdata == '0 || rdata == MID)); // R2
  AST_COMMIT_AFTER_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    nv_commit |-> $past(bus_stop)); // R5
  AST_IDLE_NO_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    !pend_v |=> !nv_commit); // R6
  AST_VOL_NO_STAGE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && vol_mode && !pend_v) |=> !pend_v); // R4
  AST_WIPER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(wiper0) && $stable(wiper1))); // R10
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == 4'd7 || addr > 4'd8) |-> rdata == '0); // R8
endmodule

// File: tb/dual_wiper_regfile_test.sv
module dual_wiper_regfile_test;
  logic clk = 0, rst_n = 0, wr_en = 0, bus_stop = 0;
  logic [3:0] addr = 0;
  logic [7:0] wdata = 0;
  logic [7:0] rdata, wiper0, wiper1, nv_data;
  logic [2:0] nv_addr;
  logic nv_commit;
  int tests = 0, fails = 0;

  dual_wiper_regfile uut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .bus_stop(bus_stop),
    .addr(addr), .wdata(wdata), .rdata(rdata), .wiper0(wiper0), .wiper1(wiper1),
    .nv_commit(nv_commit), .nv_addr(nv_addr), .nv_data(nv_data));

  always #4 clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  task automatic stop(output logic c, output logic [2:0] a, output logic [7:0] d, output logic c2);
    @(negedge clk); bus_stop = 1;
    @(negedge clk); bus_stop = 0; c = nv_commit; a = nv_addr; d = nv_data;
    @(negedge clk); c2 = nv_commit;
  endtask

  task automatic t_reset;
    logic [7:0] v;
    chk("R1 wiper0", wiper0, 8'h80);
    chk("R1 wiper1", wiper1, 8'h80);
    chk("R1 commit", nv_commit, 0);
    rd(0, v); chk("R1 ivr0", v, 8'h80);
    rd(1, v); chk("R1 ivr1", v, 8'h80);
    rd(3, v); chk("R1 gp", v, 0);
    rd(8, v); chk("R1 mode", v, 0);
  endtask

  task automatic t_mode;
    logic [7:0] v;
    wr(8, 8'h80); rd(8, v); chk("R2 set 80", v, 8'h80);
    wr(8, 8'h55); rd(8, v); chk("R2 illegal ignored", v, 8'h80);
    wr(8, 8'h00); rd(8, v); chk("R2 set 00", v, 0);
    wr(8, 8'h01); rd(8, v); chk("R2 illegal ignored 2", v, 0);
  endtask

  task automatic t_persist;
    logic [7:0] v, d; logic [2:0] a; logic c, c2;
    @(negedge clk); wr_en = 1; addr = 0; wdata = 8'h3C;
    #1 chk("R10 not before edge", wiper0, 8'h80);
    @(negedge clk); wr_en = 0;
    chk("R10 visible after edge", wiper0, 8'h3C);
    chk("R3 other channel", wiper1, 8'h80);
    rd(0, v); chk("R3 read old ivr", v, 8'h80);
    stop(c, a, d, c2);
    chk("R5 commit", c, 1); chk("R5 addr", a, 0); chk("R5 data", d, 8'h3C);
    chk("R5 single cycle", c2, 0);
    rd(0, v); chk("R5 new ivr", v, 8'h3C);
  endtask

  task automatic t_volatile;
    logic [7:0] v, d; logic [2:0] a; logic c, c2;
    wr(8, 8'h80);
    wr(1, 8'hA5);
    chk("R4 wiper1", wiper1, 8'hA5);
    rd(1, v); chk("R4 read live", v, 8'hA5);
    stop(c, a, d, c2); chk("R4 no commit", c, 0);
    wr(8, 8'h00);
    rd(1, v); chk("R4 ivr untouched", v, 8'h80);
  endtask

  task automatic t_gp;
    logic [7:0] v, d; logic [2:0] a; logic c, c2;
    wr(4, 8'h77);
    stop(c, a, d, c2);
    chk("R7 commit", c, 1); chk("R7 addr", a, 4); chk("R7 data", d, 8'h77);
    rd(4, v); chk("R7 read", v, 8'h77);
    wr(8, 8'h80);
    rd(4, v); chk("R7 vol read zero", v, 0);
    wr(4, 8'h11);
    stop(c, a, d, c2); chk("R7 vol write no commit", c, 0);
    wr(8, 8'h00);
    rd(4, v); chk("R7 value kept", v, 8'h77);
  endtask

  task automatic t_reserved;
    logic [7:0] v, d; logic [2:0] a; logic c, c2;
    wr(7, 8'hFF);
    wr(12, 8'hEE);
    stop(c, a, d, c2); chk("R8 no commit", c, 0);
    rd(7, v); chk("R8 read 7", v, 0);
    rd(12, v); chk("R8 read 12", v, 0);
    chk("R8 wipers", {wiper0, wiper1}, 16'h3CA5);
  endtask

  task automatic t_last;
    logic [7:0] v, d; logic [2:0] a; logic c, c2;
    wr(5, 8'h01);
    wr(6, 8'h02);
    stop(c, a, d, c2);
    chk("R9 commit", c, 1); chk("R9 last addr", a, 6); chk("R9 last data", d, 8'h02);
    rd(5, v); chk("R9 first lost", v, 0);
    rd(6, v); chk("R9 last stored", v, 8'h02);
    stop(c, a, d, c2); chk("R6 idle stop", c, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset; t_mode; t_persist; t_volatile; t_gp; t_reserved; t_last;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #800000;
    tests++; fails++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule